// File: doc/BRIEF.md
# Cipher command register front end

This block is the software-facing register file of a block-cipher engine that moves data by DMA. Software writes a source address, a destination address, a byte count, a 128-bit key and a 128-bit chaining vector. It then writes a control word to one of two channel control registers. When the start bit in that word is set and the transfer parameters are legal, the front end hands the operation to a back end (cipher datapath plus bus master, not part of this block) through a one-cycle launch pulse. It then waits for a one-cycle done pulse.

The start bit also serves as the busy flag. Software polls the control register until the bit reads 0. While an operation is in flight, the parameter registers and both control registers are locked against writes, so the back end sees stable values. Completion of channel A, channel B and an external nonvolatile-memory operation each set a sticky status flag. A separate sticky error flag records launch requests that were rejected. Every status source has a disable bit, and the interrupt output combines the flags with those disables.

Top module: `cipher_cmd_frontend`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `be_start` is low.
- R2: Byte offsets: control A 0x00, control B 0x04, interrupt 0x08, source 0x10, destination 0x14, length 0x18, key words 0x30–0x3C, vector words 0x40–0x4C. Source, destination and vector read back what was written, and length reads back its low LEN_W bits with the upper bits zero. Key words are write-only, read as 0, and appear on `be_key` with word n in bits [32n+31:32n]. Unmapped offsets, and any address with bits above bit 7 set, read 0.
- R3: Control word bits: 0 start, 1 encrypt (0 = decrypt), 2 writable-key select, 3 destination coherent, 4 source coherent, 5 chaining mode (1 = CBC, 0 = ECB). Bits 5:1 read back as written. During an operation they drive `be_encrypt`, `be_key_sel`, `be_dst_coh`, `be_src_coh` and `be_cbc` of the launching channel.
- R4: A legal start write sets the start bit. In the clock cycle after the write, `be_start` is high for exactly one cycle, and `be_channel` is 0 for A and 1 for B.
- R5: The start bit stays 1 until `be_done` is sampled high, and it reads 0 from the next cycle on. The same edge sets status bit 16 for channel A or bit 17 for channel B.
- R6: A start request is legal only when the length is nonzero and a multiple of ALIGN (16 bytes), and source and destination have their low log2(ALIGN) bits zero. An illegal request leaves the start bit at 0, produces no `be_start`, and sets error bit 8 of the interrupt register. The configuration bits are still stored.
- R7: While either start bit is 1, writes to source, destination, length, key, vector and both control registers have no effect.
- R8: Interrupt register bits 0, 1 and 2 are read/write disables for channel A, channel B and the nonvolatile-memory source. Bits 16, 17 and 18 are the matching status flags, and a `nv_done` pulse sets bit 18.
- R9: Status bits 16–18 and error bit 8 clear only when 1 is written to them. Writing 0 leaves them unchanged.
- R10: `irq` is high exactly when some status flag is set whose disable bit is 0. The error flag does not drive `irq`.
- R11: At most one channel is busy at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address (combinational read) |
| rd_data | output | 32 | Read data |
| be_start | output | 1 | One-cycle launch pulse to the back end |
| be_channel | output | 1 | Launching channel, 0 = A, 1 = B |
| be_encrypt | output | 1 | Encrypt (1) or decrypt (0) |
| be_cbc | output | 1 | Chaining mode (1) or codebook mode (0) |
| be_key_sel | output | 1 | Use the writable key |
| be_src_coh | output | 1 | Source coherent |
| be_dst_coh | output | 1 | Destination coherent |
| be_src | output | 32 | Source address |
| be_dst | output | 32 | Destination address |
| be_len | output | LEN_W | Byte count |
| be_key | output | 32*KEY_WORDS | Key words |
| be_iv | output | 32*IV_WORDS | Chaining vector words |
| be_done | input | 1 | One-cycle completion pulse from the back end |
| nv_done | input | 1 | One-cycle completion pulse of the nonvolatile-memory operation |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 12-bit length register and otherwise keeps the default parameters: 16-byte alignment, four key words and four vector words. The narrow length register brings truncation of the written length into reach. The bench sweeps every length from 0 to 80 and every misalignment of the low four address bits of source and destination. It also tries all 64 combinations of the three status flags against the three disable bits. A back-end model answers each launch after a delay proportional to the length. This keeps an operation in flight long enough to show that the locked registers ignore writes.

// File: rtl/cmd_fe_pkg.sv
package cmd_fe_pkg;
   // byte offsets inside the low eight address bits
   localparam logic [7:0] OFS_CTRL_A = 8'h00;
   localparam logic [7:0] OFS_CTRL_B = 8'h04;
   localparam logic [7:0] OFS_IRQ    = 8'h08;
   localparam logic [7:0] OFS_SRC    = 8'h10;
   localparam logic [7:0] OFS_DST    = 8'h14;
   localparam logic [7:0] OFS_LEN    = 8'h18;
   localparam logic [7:0] OFS_KEY    = 8'h30;
   localparam logic [7:0] OFS_IV     = 8'h40;

   // control word layout
   localparam int CB_GO   = 0;
   localparam int CFG_LSB = 1;
   localparam int CFG_W   = 5;

   // interrupt register layout
   localparam int N_SRC        = 3;
   localparam int IRQ_DIS_LSB  = 0;
   localparam int IRQ_ERR_BIT  = 8;
   localparam int IRQ_STAT_LSB = 16;

   localparam int N_CHAN = 2;

   typedef struct packed {
      logic cbc;
      logic scoh;
      logic dcoh;
      logic keysel;
      logic enc;
   } op_cfg_t;
endpackage

// File: rtl/cmd_word_bank.sv
module cmd_word_bank #(
   parameter int WORDS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          idx,
   input  logic [31:0]         wdata,
   output logic [32*WORDS-1:0] words
);
   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_word
         logic [31:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     q <= '0;
            else if (we && idx == 2'(i))    q <= wdata;
         end
         assign words[32*i +: 32] = q;
      end
   endgenerate
endmodule

// File: rtl/cmd_chan_ctrl.sv
module cmd_chan_ctrl
   import cmd_fe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [5:0] wdata,
   input  logic       any_busy,
   input  logic       params_ok,
   input  logic       done_hit,
   output op_cfg_t    cfg,
   output logic       go,
   output logic       launch,
   output logic       reject
);
   logic take;

   assign take   = wr_hit && !any_busy;
   assign launch = take && wdata[CB_GO] && params_ok;
   assign reject = take && wdata[CB_GO] && !params_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
         go  <= 1'b0;
      end else begin
         if (take)          cfg <= op_cfg_t'(wdata[CFG_LSB +: CFG_W]);
         if (launch)        go  <= 1'b1;
         else if (done_hit) go  <= 1'b0;
      end
   end
endmodule

// File: rtl/cmd_irq_unit.sv
module cmd_irq_unit #(
   parameter int NS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  logic [NS-1:0] wdis,
   input  logic [NS-1:0] wclr,
   input  logic          wclr_err,
   input  logic [NS-1:0] set_stat,
   input  logic          set_err,
   output logic [NS-1:0] dis,
   output logic [NS-1:0] stat,
   output logic          err,
   output logic          irq
);
   logic [NS-1:0] clr_mask;

   assign clr_mask = wr_hit ? wclr : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dis  <= '0;
         stat <= '0;
         err  <= 1'b0;
      end else begin
         if (wr_hit) dis <= wdis;
         // a new event wins over a clear in the same cycle
         stat <= (stat & ~clr_mask) | set_stat;
         err  <= (err & ~(wr_hit && wclr_err)) | set_err;
      end
   end

   assign irq = |(stat & ~dis);
endmodule

// File: rtl/cipher_cmd_frontend.sv
module cipher_cmd_frontend
   import cmd_fe_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LEN_W     = 16,
   parameter int ALIGN     = 16,
   parameter int KEY_WORDS = 4,
   parameter int IV_WORDS  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [31:0]            wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [31:0]            rd_data,
   output logic                   be_start,
   output logic                   be_channel,
   output logic                   be_encrypt,
   output logic                   be_cbc,
   output logic                   be_key_sel,
   output logic                   be_src_coh,
   output logic                   be_dst_coh,
   output logic [31:0]            be_src,
   output logic [31:0]            be_dst,
   output logic [LEN_W-1:0]       be_len,
   output logic [32*KEY_WORDS-1:0] be_key,
   output logic [32*IV_WORDS-1:0] be_iv,
   input  logic                   be_done,
   input  logic                   nv_done,
   output logic                   irq
);
   localparam int AL = $clog2(ALIGN);

   generate
      if (ALIGN < 2 || (ALIGN & (ALIGN - 1)) != 0) begin : g_bad_align
         $error("ALIGN must be a power of two of at least 2");
      end
      if (LEN_W <= AL || LEN_W > 32) begin : g_bad_len
         $error("LEN_W must exceed log2(ALIGN) and be at most 32");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must be at least 9");
      end
      if (KEY_WORDS < 1 || KEY_WORDS > 4 || IV_WORDS < 1 || IV_WORDS > 4) begin : g_bad_words
         $error("KEY_WORDS and IV_WORDS must be 1 to 4");
      end
   endgenerate

   // ---------------- write decode ----------------
   logic w_page;
   logic w_src, w_dst, w_len, w_irq, w_key, w_iv;
   logic [N_CHAN-1:0] w_ctrl;
   logic busy;

   assign w_page    = wr_en && (wr_addr[ADDR_W-1:8] == '0);
   assign w_ctrl[0] = w_page && wr_addr[7:0] == OFS_CTRL_A;
   assign w_ctrl[1] = w_page && wr_addr[7:0] == OFS_CTRL_B;
   assign w_irq     = w_page && wr_addr[7:0] == OFS_IRQ;
   assign w_src     = w_page && wr_addr[7:0] == OFS_SRC && !busy;
   assign w_dst     = w_page && wr_addr[7:0] == OFS_DST && !busy;
   assign w_len     = w_page && wr_addr[7:0] == OFS_LEN && !busy;
   assign w_key     = w_page && wr_addr[7:4] == OFS_KEY[7:4] && wr_addr[1:0] == 2'b00 && !busy;
   assign w_iv      = w_page && wr_addr[7:4] == OFS_IV[7:4]  && wr_addr[1:0] == 2'b00 && !busy;

   // ---------------- parameter registers ----------------
   logic [31:0]      src_q, dst_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         len_q <= '0;
      end else begin
         if (w_src) src_q <= wr_data;
         if (w_dst) dst_q <= wr_data;
         if (w_len) len_q <= wr_data[LEN_W-1:0];
      end
   end

   logic [32*KEY_WORDS-1:0] key_flat;
   logic [32*IV_WORDS-1:0]  iv_flat;

   cmd_word_bank #(.WORDS(KEY_WORDS)) u_key (
      .clk(clk), .rst_n(rst_n), .we(w_key), .idx(wr_addr[3:2]),
      .wdata(wr_data), .words(key_flat));

   cmd_word_bank #(.WORDS(IV_WORDS)) u_iv (
      .clk(clk), .rst_n(rst_n), .we(w_iv), .idx(wr_addr[3:2]),
      .wdata(wr_data), .words(iv_flat));

   // ---------------- legality of a launch ----------------
   logic params_ok;
   assign params_ok = (len_q != '0) && (len_q[AL-1:0] == '0) &&
                      (src_q[AL-1:0] == '0) && (dst_q[AL-1:0] == '0);

   // ---------------- channel control registers ----------------
   op_cfg_t           cfg [N_CHAN];
   logic [N_CHAN-1:0] go, launch, reject, done_hit;

   assign busy = |go;

   generate
      for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
         assign done_hit[c] = be_done && go[c];
         cmd_chan_ctrl u_ctl (
            .clk(clk), .rst_n(rst_n), .wr_hit(w_ctrl[c]), .wdata(wr_data[5:0]),
            .any_busy(busy), .params_ok(params_ok), .done_hit(done_hit[c]),
            .cfg(cfg[c]), .go(go[c]), .launch(launch[c]), .reject(reject[c]));
      end
   endgenerate

   // ---------------- launch pulse and active channel ----------------
   logic ch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         be_start <= 1'b0;
         ch_q     <= 1'b0;
      end else begin
         be_start <= |launch;
         if (|launch) ch_q <= launch[1];
      end
   end

   op_cfg_t act_cfg;
   assign act_cfg    = ch_q ? cfg[1] : cfg[0];
   assign be_channel = ch_q;
   assign be_encrypt = act_cfg.enc;
   assign be_cbc     = act_cfg.cbc;
   assign be_key_sel = act_cfg.keysel;
   assign be_src_coh = act_cfg.scoh;
   assign be_dst_coh = act_cfg.dcoh;
   assign be_src     = src_q;
   assign be_dst     = dst_q;
   assign be_len     = len_q;
   assign be_key     = key_flat;
   assign be_iv      = iv_flat;

   // ---------------- status and interrupt ----------------
   logic [N_SRC-1:0] dis, stat;
   logic             err;

   cmd_irq_unit #(.NS(N_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .wr_hit(w_irq),
      .wdis(wr_data[IRQ_DIS_LSB +: N_SRC]),
      .wclr(wr_data[IRQ_STAT_LSB +: N_SRC]),
      .wclr_err(wr_data[IRQ_ERR_BIT]),
      .set_stat({nv_done, done_hit[1], done_hit[0]}),
      .set_err(|reject),
      .dis(dis), .stat(stat), .err(err), .irq(irq));

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      if (rd_addr[ADDR_W-1:8] == '0) begin
         case (rd_addr[7:0])
            OFS_CTRL_A: rd_data = {26'd0, cfg[0], go[0]};
            OFS_CTRL_B: rd_data = {26'd0, cfg[1], go[1]};
            OFS_IRQ:    rd_data = {13'd0, stat, 7'd0, err, 5'd0, dis};
            OFS_SRC:    rd_data = src_q;
            OFS_DST:    rd_data = dst_q;
            OFS_LEN:    rd_data = 32'(len_q);
            default:    rd_data = '0;
         endcase
         for (int i = 0; i < IV_WORDS; i++) begin
            if (rd_addr[7:0] == OFS_IV + 8'(4 * i)) rd_data = iv_flat[32*i +: 32];
         end
      end
   end
endmodule

// File: rtl/cmd_fe_checker.sv
module cmd_fe_checker #(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = 16,
   parameter int AL     = 4,
   parameter int KW     = 128,
   parameter int IW     = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_go,
   input logic              be_start,
   input logic              be_done,
   input logic [31:0]       be_src,
   input logic [31:0]       be_dst,
   input logic [LEN_W-1:0]  be_len,
   input logic [KW-1:0]     be_key,
   input logic [IW-1:0]     be_iv,
   input logic              irq,
   input logic [1:0]        go,
   input logic [2:0]        dis,
   input logic              err
);
   logic busy, irq_wr, ctl_a_start;
   assign busy        = |go;
   assign irq_wr      = wr_en && wr_addr == ADDR_W'(8'h08);
   assign ctl_a_start = wr_en && wr_addr == '0 && wr_go;

   assert_single_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(go));

   assert_launch_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |=> !be_start);

   assert_launch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |-> busy);

   assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && busy) |=> !busy);

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(be_src) && $stable(be_dst) && $stable(be_len) &&
                $stable(be_key) && $stable(be_iv)));

   assert_reject_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_a_start && !busy && be_len[AL-1:0] != '0) |=> (!busy && err));

   assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && go[0] && !dis[0] && !irq_wr) |=> irq);

   assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dis == 3'b111) |-> !irq);
endmodule

bind cipher_cmd_frontend cmd_fe_checker #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .AL($clog2(ALIGN)),
   .KW(32*KEY_WORDS), .IW(32*IV_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_go(wr_data[0]),
   .be_start(be_start), .be_done(be_done), .be_src(be_src), .be_dst(be_dst),
   .be_len(be_len), .be_key(be_key), .be_iv(be_iv), .irq(irq),
   .go(go), .dis(dis), .err(err)
);

// File: tb/sim_cipher_cmd_frontend.sv
`timescale 1ns/1ps
module sim_cipher_cmd_frontend;
   localparam int ADDR_W = 12;
   localparam int LEN_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [31:0]       rd_data;
   logic be_start, be_channel, be_encrypt, be_cbc, be_key_sel, be_src_coh, be_dst_coh;
   logic [31:0]       be_src, be_dst;
   logic [LEN_W-1:0]  be_len;
   logic [127:0]      be_key, be_iv;
   logic              be_done = 1'b0;
   logic              nv_done = 1'b0;
   logic              irq;

   int nchk = 0;
   int nfail = 0;
   int nstarts = 0;
   logic [31:0] cap_src, cap_dst, cap_key0;
   logic [LEN_W-1:0] cap_len;
   logic [5:0]  cap_flags; // {cbc,scoh,dcoh,keysel,enc,channel}

   always #4 clk = ~clk;

   cipher_cmd_frontend #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .be_start(be_start), .be_channel(be_channel),
      .be_encrypt(be_encrypt), .be_cbc(be_cbc), .be_key_sel(be_key_sel),
      .be_src_coh(be_src_coh), .be_dst_coh(be_dst_coh), .be_src(be_src), .be_dst(be_dst),
      .be_len(be_len), .be_key(be_key), .be_iv(be_iv), .be_done(be_done),
      .nv_done(nv_done), .irq(irq));

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_idle(input logic [ADDR_W-1:0] ctl);
      logic [31:0] v;
      for (int k = 0; k < 5000; k++) begin
         rd(ctl, v);
         if (!v[0]) break;
         @(negedge clk);
      end
   endtask

   task automatic pulse_nv();
      @(negedge clk); nv_done = 1'b1;
      @(negedge clk); nv_done = 1'b0;
   endtask

   // back end model: done after a delay proportional to the length
   initial begin
      forever begin
         @(negedge clk);
         if (be_start) begin
            int n;
            nstarts++;
            cap_src  = be_src; cap_dst = be_dst; cap_len = be_len;
            cap_key0 = be_key[31:0];
            cap_flags = {be_cbc, be_src_coh, be_dst_coh, be_key_sel, be_encrypt, be_channel};
            n = int'(be_len) / 16 * 2 + 3;
            @(negedge clk);
            chk(!be_start, "R4", "launch pulse width", 32'(be_start), 32'd0);
            repeat (n - 1) @(negedge clk);
            be_done = 1'b1;
            @(negedge clk);
            be_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      int s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      foreach (v[i]) ; // no-op keeps v declared usage simple
      rd(12'h000, v); chk(v == 0, "R1", "ctrl A reset", v, 0);
      rd(12'h004, v); chk(v == 0, "R1", "ctrl B reset", v, 0);
      rd(12'h008, v); chk(v == 0, "R1", "irq reg reset", v, 0);
      rd(12'h010, v); chk(v == 0, "R1", "src reset", v, 0);
      rd(12'h018, v); chk(v == 0, "R1", "len reset", v, 0);
      chk(!irq && !be_start, "R1", "irq/be_start reset", {30'd0, irq, be_start}, 0);

      // R2 register map
      wr(12'h010, 32'h0000_1230); wr(12'h014, 32'h0000_4560);
      wr(12'h018, 32'hFFFF_F0F0);
      rd(12'h010, v); chk(v == 32'h1230, "R2", "src readback", v, 32'h1230);
      rd(12'h014, v); chk(v == 32'h4560, "R2", "dst readback", v, 32'h4560);
      rd(12'h018, v); chk(v == 32'h0F0, "R2", "len truncated", v, 32'h0F0);
      for (int i = 0; i < 4; i++) begin
         wr(12'(12'h030 + 4 * i), 32'hA000_0000 + 32'(i));
         wr(12'(12'h040 + 4 * i), 32'hB000_0000 + 32'(i));
      end
      for (int i = 0; i < 4; i++) begin
         rd(12'(12'h030 + 4 * i), v); chk(v == 0, "R2", "key reads zero", v, 0);
         rd(12'(12'h040 + 4 * i), v);
         chk(v == 32'hB000_0000 + 32'(i), "R2", "iv readback", v, 32'hB000_0000 + 32'(i));
         chk(be_key[32*i +: 32] == 32'hA000_0000 + 32'(i), "R2", "key on port",
             be_key[32*i +: 32], 32'hA000_0000 + 32'(i));
      end
      rd(12'h00C, v); chk(v == 0, "R2", "unmapped 0x0C", v, 0);
      rd(12'h020, v); chk(v == 0, "R2", "unmapped 0x20", v, 0);
      rd(12'h110, v); chk(v == 0, "R2", "upper address bits", v, 0);

      // R4 R5 R6 length sweep
      wr(12'h010, 32'h100); wr(12'h014, 32'h200);
      for (int len = 0; len <= 80; len++) begin
         bit acc;
         acc = (len != 0) && (len % 16 == 0);
         s0 = nstarts;
         wr(12'h018, 32'(len));
         wr(12'h000, 32'h23);
         rd(12'h000, v);
         chk(v == (acc ? 32'h23 : 32'h22), "R6", "start after length", v, acc ? 32'h23 : 32'h22);
         rd(12'h008, v);
         chk(v[8] == !acc, "R6", "error flag", 32'(v[8]), 32'(!acc));
         if (acc) begin
            wait_idle(12'h000);
            @(negedge clk);
            rd(12'h008, v);
            chk(v[16], "R5", "channel A done flag", v, 32'h10000);
            chk(cap_len == LEN_W'(len) && cap_flags[0] == 1'b0, "R4", "launch length/channel",
                32'({cap_flags[0], cap_len}), 32'(len));
            rd(12'h000, v); chk(v == 32'h22, "R5", "start cleared", v, 32'h22);
         end else begin
            @(negedge clk);
            chk(nstarts == s0, "R6", "no launch on reject", 32'(nstarts), 32'(s0));
         end
         wr(12'h008, 32'h0007_0100);
      end

      // R6 alignment sweep on source then destination
      wr(12'h018, 32'd32);
      for (int w = 0; w < 2; w++) begin
         for (int s = 0; s < 16; s++) begin
            wr(w == 0 ? 12'h010 : 12'h014, 32'h300 + 32'(s));
            wr(w == 0 ? 12'h014 : 12'h010, 32'h500);
            wr(12'h000, 32'h01);
            rd(12'h000, v);
            chk(v[0] == (s == 0), "R6", "start vs alignment", 32'(v[0]), 32'(s == 0));
            rd(12'h008, v);
            chk(v[8] == (s != 0), "R6", "error vs alignment", 32'(v[8]), 32'(s != 0));
            wait_idle(12'h000);
            @(negedge clk);
            wr(12'h008, 32'h0007_0100);
         end
      end

      // R7 writes ignored while busy
      wr(12'h010, 32'h100); wr(12'h014, 32'h200); wr(12'h018, 32'd256);
      wr(12'h030, 32'hA5A5_A5A5); wr(12'h040, 32'h1111_1111);
      wr(12'h000, 32'h03);
      wr(12'h010, 32'h300); wr(12'h014, 32'h400); wr(12'h018, 32'h20);
      wr(12'h030, 32'hDEAD_0000); wr(12'h040, 32'h2222_2222);
      wr(12'h004, 32'h3F); wr(12'h000, 32'h20);
      rd(12'h010, v); chk(v == 32'h100, "R7", "src locked", v, 32'h100);
      rd(12'h014, v); chk(v == 32'h200, "R7", "dst locked", v, 32'h200);
      rd(12'h018, v); chk(v == 32'd256, "R7", "len locked", v, 32'd256);
      rd(12'h040, v); chk(v == 32'h1111_1111, "R7", "iv locked", v, 32'h1111_1111);
      chk(be_key[31:0] == 32'hA5A5_A5A5, "R7", "key locked", be_key[31:0], 32'hA5A5_A5A5);
      rd(12'h004, v); chk(v == 0, "R7", "ctrl B locked", v, 0);
      rd(12'h000, v); chk(v == 32'h03, "R7", "ctrl A locked", v, 32'h03);
      wait_idle(12'h000);
      @(negedge clk);
      chk(cap_src == 32'h100 && cap_key0 == 32'hA5A5_A5A5, "R7", "launched values",
          cap_src, 32'h100);
      wr(12'h010, 32'h700);
      rd(12'h010, v); chk(v == 32'h700, "R7", "write accepted when idle", v, 32'h700);
      wr(12'h010, 32'h100);
      wr(12'h008, 32'h0007_0100);

      // R3 control bit mapping, both channels
      wr(12'h018, 32'd16);
      wr(12'h004, 32'h3F);
      wait_idle(12'h004); @(negedge clk);
      chk(cap_flags == 6'b111111, "R3", "all cfg bits channel B", 32'(cap_flags), 32'h3F);
      rd(12'h004, v); chk(v == 32'h3E, "R3", "ctrl B readback", v, 32'h3E);
      rd(12'h008, v); chk(v[18:16] == 3'b010, "R5", "channel B flag", v, 32'h20000);
      wr(12'h000, 32'h15);
      wait_idle(12'h000); @(negedge clk);
      chk(cap_flags == 6'b010100, "R3", "cfg 0x15 channel A", 32'(cap_flags), 32'h14);
      wr(12'h008, 32'h0007_0100);

      // R8 R10 flags against disables
      for (int f = 0; f < 8; f++) begin
         for (int d = 0; d < 8; d++) begin
            wr(12'h008, 32'h0007_0100 | 32'(d));
            if (f[0]) begin wr(12'h000, 32'h01); wait_idle(12'h000); @(negedge clk); end
            if (f[1]) begin wr(12'h004, 32'h01); wait_idle(12'h004); @(negedge clk); end
            if (f[2]) pulse_nv();
            rd(12'h008, v);
            chk(v == ((32'(f) << 16) | 32'(d)), "R8", "irq register", v, (32'(f) << 16) | 32'(d));
            chk(irq == |(3'(f) & ~3'(d)), "R10", "irq output", 32'(irq), 32'(|(3'(f) & ~3'(d))));
         end
      end

      // R9 write-one-to-clear
      wr(12'h008, 32'h0);
      rd(12'h008, v); chk(v == 32'h0007_0000, "R9", "zero write keeps", v, 32'h0007_0000);
      wr(12'h008, 32'h0002_0000);
      rd(12'h008, v); chk(v == 32'h0005_0000, "R9", "clear bit 17 only", v, 32'h0005_0000);
      wr(12'h008, 32'h0005_0000);
      wr(12'h018, 32'd24); wr(12'h000, 32'h01);
      rd(12'h008, v); chk(v == 32'h100, "R9", "error set", v, 32'h100);
      chk(!irq, "R10", "error not in irq", 32'(irq), 0);
      wr(12'h008, 32'h0);
      rd(12'h008, v); chk(v == 32'h100, "R9", "error kept on zero", v, 32'h100);
      wr(12'h008, 32'h100);
      rd(12'h008, v); chk(v == 0, "R9", "error cleared", v, 0);

      summary();
   end
endmodule